// File: doc/BRIEF.md
# Accumulating Add/Subtract Datapath

This block is a narrow arithmetic slice that folds an external operand A into either a fresh external operand B or its own stored result. Each cycle the second operand is chosen by a select input. A subtract input turns the operation into "second operand minus A" by complementing A and forcing a carry into the lowest bit. The outcome is written into a result register only when a load input is high.

The register captures on the falling edge of the clock, because the clock is qualified so that capture occurs at the end of the clock-high phase. It is built as one clock domain with load acting as an enable, so no derived clock exists. An active-high synchronous reset clears the stored result. The carry out of the most significant bit is available combinationally. With select low and load held high, repeated cycles accumulate A into the result or subtract A from it.

Top module: `accum_addsub`

## Requirements
- R1: While `rst` is high at a falling clock edge, `q` becomes 0 after that edge, whatever the other inputs are.
- R2: When `load` is low (and `rst` low) at a falling edge, `q` keeps its value.
- R3: With `use_b` = 0, the second operand is the current `q`. A load therefore stores `q` plus A, or `q` minus A.
- R4: With `use_b` = 1, the second operand is `b`. A load therefore stores `b` plus A, or `b` minus A.
- R5: With `sub` = 0, the stored value is (operand + `a`) mod 2^W.
- R6: With `sub` = 1, the stored value is (operand − `a`) mod 2^W. This is formed as operand + ~`a` + 1.
- R7: `carry_out` is bit W of operand + (`a` XOR {W{`sub`}}) + `sub`. For example, 0xFF + 0x01 gives `q` = 0x00 and `carry_out` = 1. Subtracting with operand ≥ A gives 1.
- R8: `q` changes only at a falling clock edge. It is unchanged just after every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; result captured on its falling edge |
| rst | input | 1 | Active-high synchronous clear of the result |
| a | input | W | Operand that is added or subtracted |
| b | input | W | Fresh operand, used when `use_b` is high |
| use_b | input | 1 | 1 selects `b`, 0 selects the stored result |
| sub | input | 1 | 1 subtracts `a`, 0 adds it |
| load | input | 1 | Enables capture of the sum at the falling edge |
| q | output | W | Stored result |
| carry_out | output | 1 | Carry out of the top bit of the current sum |

## Verification
The assertions sample at the falling edge. They assume that `a`, `b`, `use_b`, `sub`, `load` and `rst` are settled there and have no X values once reset has been seen. The stimulus keeps to this by changing every input just after the rising edge, which leaves half a period before each capture. Reset is held across several falling edges before any operation starts.

// File: rtl/accum_addsub.sv
module accum_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         use_b,
  input  logic         sub,
  input  logic         load,
  output logic [W-1:0] q,
  output logic         carry_out
);

  logic [W-1:0] opnd;
  logic [W-1:0] a_x;
  logic [W-1:0] sum;
  logic [W:0]   cy;

  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign opnd[i]  = use_b ? b[i] : q[i];
    assign a_x[i]   = a[i] ^ sub;
    assign sum[i]   = opnd[i] ^ a_x[i] ^ cy[i];
    assign cy[i+1]  = (opnd[i] & a_x[i]) | (cy[i] & (opnd[i] | a_x[i]));
  end

  assign carry_out = cy[W];

  always_ff @(negedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= sum;
  end

  logic [W:0] wide_ref;
  assign wide_ref = {1'b0, (use_b ? b : q)} + {1'b0, (sub ? ~a : a)} + {{W{1'b0}}, sub};

  assert_reset_clears_R1: assert property (@(negedge clk) rst |=> q == '0);

  assert_hold_no_load_R2: assert property (@(negedge clk) disable iff (rst)
    !load |=> $stable(q));

  assert_acc_add_R3: assert property (@(negedge clk) disable iff (rst)
    (load && !use_b && !sub) |=> q == $past(q) + $past(a));

  assert_fresh_sub_R4: assert property (@(negedge clk) disable iff (rst)
    (load && use_b && sub) |=> q == $past(b) - $past(a));

  assert_acc_sub_R6: assert property (@(negedge clk) disable iff (rst)
    (load && !use_b && sub) |=> q == $past(q) - $past(a));

  assert_fresh_add_R5: assert property (@(negedge clk) disable iff (rst)
    (load && use_b && !sub) |=> q == $past(b) + $past(a));

  assert_carry_R7: assert property (@(negedge clk) disable iff (rst)
    carry_out == wide_ref[W]);

endmodule

// File: tb/accum_addsub_test.sv
module accum_addsub_test;
  localparam int W = 8;
  localparam time PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [W-1:0] a = 0, b = 0;
  logic use_b = 0, sub = 0, load = 0;
  logic [W-1:0] q;
  logic carry_out;

  int checks = 0, fails = 0;
  logic [W-1:0] exp_q = 0;
  bit done = 0;

  accum_addsub #(.W(W)) uut (.clk, .rst, .a, .b, .use_b, .sub, .load, .q, .carry_out);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit rs, input bit ld, input bit ub, input bit sb,
                      input logic [W-1:0] av, input logic [W-1:0] bv);
    logic [W:0] tot;
    logic [W-1:0] op;
    string tag;
    @(posedge clk); #1;
    chk("R8 no change at rising edge", q, exp_q);
    rst = rs; load = ld; use_b = ub; sub = sb; a = av; b = bv;
    op  = ub ? bv : exp_q;
    tot = {1'b0, op} + {1'b0, (sb ? ~av : av)} + {{W{1'b0}}, sb};
    #1;
    if (!rs) chk("R7 carry_out", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, tot[W]});
    if (rs) begin exp_q = 0; tag = "R1 reset"; end
    else if (!ld) tag = "R2 hold";
    else begin
      exp_q = tot[W-1:0];
      if (ub) tag = sb ? "R4 R6 b-a" : "R4 R5 b+a";
      else    tag = sb ? "R3 R6 q-a" : "R3 R5 q+a";
    end
    @(negedge clk); #1;
    chk(tag, q, exp_q);
  endtask

  initial begin
    #(PERIOD*20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(1, 1, 1, 0, 8'h33, 8'h44);
    step(1, 0, 0, 0, 8'h00, 8'h00);
    step(0, 1, 1, 0, 8'h05, 8'h10);   // 0x15
    step(0, 1, 0, 0, 8'h03, 8'h99);   // 0x18
    step(0, 0, 1, 1, 8'h77, 8'h22);   // hold
    step(0, 1, 1, 0, 8'h00, 8'hFF);   // 0xFF
    step(0, 1, 0, 0, 8'h01, 8'h00);   // wrap to 0, carry 1
    step(0, 1, 1, 1, 8'h05, 8'h03);   // 0xFE, carry 0
    step(0, 1, 0, 1, 8'h0E, 8'h00);   // 0xF0, carry 1
    step(0, 1, 0, 1, 8'h00, 8'h00);   // minus zero, carry 1
    step(0, 0, 0, 0, 8'hFF, 8'hFF);   // hold
    step(1, 1, 1, 1, 8'h12, 8'h34);   // reset overrides load
    for (int i = 0; i < 300; i++)
      step(($urandom % 23) == 0, ($urandom % 4) != 0, $urandom % 2, $urandom % 2,
           W'($urandom), W'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule